// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank Controller

This block controls one bank of general-purpose pins through a simple APB-style register interface. Each pin holds a stored output level, a direction bit and a pull-off bit. The level and the direction can also be changed one pin at a time through atomic set and clear aliases, so software never needs a read-modify-write sequence. A two-bit selector for each pin leaves the pad under GPIO control or hands it to one of three peripheral functions. Each of those functions supplies its own drive level and drive enable.

A small bus-phase state machine tracks the transfer protocol. `BUS_IDLE` moves to `BUS_SETUP` when select is high and enable is low. `BUS_SETUP` stays in place while the setup phase is held. It moves to `BUS_ACCESS` on the enable cycle, and that cycle commits a write or returns read data. It falls back to `BUS_IDLE` when select drops. `BUS_ACCESS` returns to `BUS_SETUP` for a back-to-back transfer and otherwise goes to `BUS_IDLE`. An enable cycle that has no setup phase before it is not a transfer. Every transfer completes with no wait states.

For a pin acting as an input, the stored level chooses the pull direction. The pull resistor is enabled only while the pad is not driven, whether GPIO or a peripheral controls the pad. Pad inputs pass through a two-flop synchronizer before they appear in the level read.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and on release, every pin is a GPIO input. The drive enable is 0, the alternate code is 0, the pull is enabled and the pull direction is down (the pull-up select is 0).
- R2: Writing offset 0x00 loads the stored output levels, 0x0C loads pull-off, 0x10 loads direction (1 = output), 0x20 loads selector bit A and 0x24 loads selector bit B. Reads of 0x0C, 0x10, 0x20 and 0x24 return the stored words.
- R3: A write to 0x04 sets, and a write to 0x08 clears, each stored level bit written as 1. Offsets 0x14 and 0x18 do the same to the direction bits. Bits written as 0 are unchanged.
- R4: The pull enable of a pin is 1 exactly when its pull-off bit is 0 and its pad is not driven. The pull-up select equals the stored level bit (1 = up, 0 = down).
- R5: A read of offset 0x00 returns the pad input levels as seen by a two-flop synchronizer. A level applied before one clock edge is not yet visible. A level held across two edges is visible.
- R6: A pin's alternate code is {bit B, bit A}. Code 0 drives the pad from the direction bit and the stored level. Code k (1 to 3) takes drive enable and level from peripheral function k, at bit (k-1)*32+pin of the peripheral buses. The code is presented on the pin's two-bit alternate output.
- R7: Reads of 0x04, 0x08, 0x14, 0x18, 0x1C and unmapped offsets return 0. Writes to 0x1C and to unmapped offsets change no state.
- R8: A write commits on the enable cycle that follows a setup phase. An enable cycle with no setup phase before it has no effect.
- R9: The read data bus is 0 outside the enable cycle of a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pad_in | input | 32 | Pad input levels |
| per_out | input | 96 | Drive levels of peripheral functions 1..3, 32 bits each |
| per_oe | input | 96 | Drive enables of peripheral functions 1..3, 32 bits each |
| pad_oe | output | 32 | Pad drive enable per pin |
| pad_out | output | 32 | Pad drive level per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction per pin, 1 = up |
| pad_alt | output | 64 | Two-bit alternate code per pin |

## Verification
The bench builds the block with its default parameters: 32 pins, an 8-bit offset and two synchronizer stages. At these values every register offset, including the reserved 0x1C and unmapped words such as 0x28 and 0xFC, can be reached by the random traffic. The three peripheral function slices are fully populated, so every alternate code on every pin can be exercised. The two-stage synchronizer makes the one-edge-too-early and two-edges-visible read cases observable directly at the bus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_state_t;

    localparam int OFS_LEVEL    = 'h00;
    localparam int OFS_LEVEL_S  = 'h04;
    localparam int OFS_LEVEL_C  = 'h08;
    localparam int OFS_PULLOFF  = 'h0C;
    localparam int OFS_DIR      = 'h10;
    localparam int OFS_DIR_S    = 'h14;
    localparam int OFS_DIR_C    = 'h18;
    localparam int OFS_ALT_A    = 'h20;
    localparam int OFS_ALT_B    = 'h24;

    localparam int NUM_FUNCS    = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (g == 0) begin
                stage_q[g] <= din;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [NPINS-1:0] pwdata,
    input  logic [NPINS-1:0] pin_level,
    output logic [NPINS-1:0] prdata,
    output logic [NPINS-1:0] level_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] pulloff_q,
    output logic [NPINS-1:0] alta_q,
    output logic [NPINS-1:0] altb_q
);
    bus_state_t state_q, state_d;
    logic       enable_ok;
    logic       wr_fire;
    logic       rd_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        enable_ok = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (psel && !penable) state_d = BUS_SETUP;
            end
            BUS_SETUP: begin
                if (!psel) begin
                    state_d = BUS_IDLE;
                end else if (penable) begin
                    state_d   = BUS_ACCESS;
                    enable_ok = 1'b1;
                end
            end
            BUS_ACCESS: begin
                if (psel && !penable) state_d = BUS_SETUP;
                else                  state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    assign wr_fire = enable_ok && pwrite;
    assign rd_fire = enable_ok && !pwrite;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q   <= '0;
            dir_q     <= '0;
            pulloff_q <= '0;
            alta_q    <= '0;
            altb_q    <= '0;
        end else if (wr_fire) begin
            case (int'(paddr))
                OFS_LEVEL:   level_q   <= pwdata;
                OFS_LEVEL_S: level_q   <= level_q | pwdata;
                OFS_LEVEL_C: level_q   <= level_q & ~pwdata;
                OFS_PULLOFF: pulloff_q <= pwdata;
                OFS_DIR:     dir_q     <= pwdata;
                OFS_DIR_S:   dir_q     <= dir_q | pwdata;
                OFS_DIR_C:   dir_q     <= dir_q & ~pwdata;
                OFS_ALT_A:   alta_q    <= pwdata;
                OFS_ALT_B:   altb_q    <= pwdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_fire) begin
            case (int'(paddr))
                OFS_LEVEL:   prdata = pin_level;
                OFS_PULLOFF: prdata = pulloff_q;
                OFS_DIR:     prdata = dir_q;
                OFS_ALT_A:   prdata = alta_q;
                OFS_ALT_B:   prdata = altb_q;
                default:     prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]           level_q,
    input  logic [NPINS-1:0]           dir_q,
    input  logic [NPINS-1:0]           pulloff_q,
    input  logic [NPINS-1:0]           alta_q,
    input  logic [NPINS-1:0]           altb_q,
    input  logic [NUM_FUNCS*NPINS-1:0] per_out,
    input  logic [NUM_FUNCS*NPINS-1:0] per_oe,
    output logic [NPINS-1:0]           pad_oe,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_pull_en,
    output logic [NPINS-1:0]           pad_pull_up,
    output logic [2*NPINS-1:0]         pad_alt
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [1:0] code;
        logic       oe;
        logic       lvl;

        assign code = {altb_q[p], alta_q[p]};

        always_comb begin
            unique case (code)
                2'd0: begin oe = dir_q[p];             lvl = level_q[p];            end
                2'd1: begin oe = per_oe[p];            lvl = per_out[p];            end
                2'd2: begin oe = per_oe[NPINS+p];      lvl = per_out[NPINS+p];      end
                2'd3: begin oe = per_oe[2*NPINS+p];    lvl = per_out[2*NPINS+p];    end
                default: begin oe = 1'b0;              lvl = 1'b0;                  end
            endcase
        end

        assign pad_oe[p]      = oe;
        assign pad_out[p]     = lvl;
        assign pad_pull_en[p] = !pulloff_q[p] && !oe;
        assign pad_pull_up[p] = level_q[p];
        assign pad_alt[2*p +: 2] = code;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [AW-1:0]              paddr,
    input  logic [NPINS-1:0]           pwdata,
    output logic [NPINS-1:0]           prdata,
    input  logic [NPINS-1:0]           pad_in,
    input  logic [NUM_FUNCS*NPINS-1:0] per_out,
    input  logic [NUM_FUNCS*NPINS-1:0] per_oe,
    output logic [NPINS-1:0]           pad_oe,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_pull_en,
    output logic [NPINS-1:0]           pad_pull_up,
    output logic [2*NPINS-1:0]         pad_alt
);
    logic [NPINS-1:0] pin_level;
    logic [NPINS-1:0] level_q, dir_q, pulloff_q, alta_q, altb_q;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_level)
    );

    gpio_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .pin_level (pin_level),
        .prdata    (prdata),
        .level_q   (level_q),
        .dir_q     (dir_q),
        .pulloff_q (pulloff_q),
        .alta_q    (alta_q),
        .altb_q    (altb_q)
    );

    gpio_padmux #(.NPINS(NPINS)) u_mux (
        .level_q     (level_q),
        .dir_q       (dir_q),
        .pulloff_q   (pulloff_q),
        .alta_q      (alta_q),
        .altb_q      (altb_q),
        .per_out     (per_out),
        .per_oe      (per_oe),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up),
        .pad_alt     (pad_alt)
    );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [AW-1:0]      paddr,
    input logic [NPINS-1:0]   prdata,
    input logic [NPINS-1:0]   pad_in,
    input logic [NPINS-1:0]   pad_oe,
    input logic [NPINS-1:0]   pad_pull_en,
    input logic [2*NPINS-1:0] pad_alt
);
    logic [1:0] since_rst;
    logic       rd_cycle;
    logic       alias_ofs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign rd_cycle  = psel && penable && !pwrite;
    assign alias_ofs = (paddr == AW'('h04)) || (paddr == AW'('h08)) ||
                       (paddr == AW'('h14)) || (paddr == AW'('h18)) ||
                       (paddr == AW'('h1C));

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_alt == '0 && pad_pull_en == '1));

    p_pull_only_undriven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);

    p_sync_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && rd_cycle && $past(psel && !penable) &&
         paddr == '0 && pad_in == $past(pad_in) && pad_in == $past(pad_in, 2))
        |-> prdata == pad_in);

    p_alias_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cycle && alias_ofs) |-> prdata == '0);

    p_idle_bus_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cycle |-> prdata == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .prdata      (prdata),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .pad_alt     (pad_alt)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
    localparam int N  = 32;
    localparam int AW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0]  paddr = '0;
    logic [N-1:0]   pwdata = '0;
    logic [N-1:0]   prdata;
    logic [N-1:0]   pad_in = '0;
    logic [3*N-1:0] per_out = '0, per_oe = '0;
    logic [N-1:0]   pad_oe, pad_out, pad_pull_en, pad_pull_up;
    logic [2*N-1:0] pad_alt;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [N-1:0] m_lvl = '0, m_dir = '0, m_poff = '0, m_a = '0, m_b = '0;
    logic [N-1:0]   e_oe, e_out, e_pen, e_pup;
    logic [2*N-1:0] e_alt;

    always #2 clk = ~clk;

    gpio_bank #(.NPINS(N), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pad_in(pad_in), .per_out(per_out), .per_oe(per_oe),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .pad_alt(pad_alt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_read(input logic [AW-1:0] a, input logic [N-1:0] pins);
        case (a)
            8'h00: return pins;
            8'h0C: return m_poff;
            8'h10: return m_dir;
            8'h20: return m_a;
            8'h24: return m_b;
            default: return '0;
        endcase
    endfunction

    function automatic void model_write(input logic [AW-1:0] a, input logic [N-1:0] w);
        case (a)
            8'h00: m_lvl  = w;
            8'h04: m_lvl  = m_lvl | w;
            8'h08: m_lvl  = m_lvl & ~w;
            8'h0C: m_poff = w;
            8'h10: m_dir  = w;
            8'h14: m_dir  = m_dir | w;
            8'h18: m_dir  = m_dir & ~w;
            8'h20: m_a    = w;
            8'h24: m_b    = w;
            default: ;
        endcase
    endfunction

    function automatic void model_pads();
        for (int i = 0; i < N; i++) begin
            int k;
            k = {m_b[i], m_a[i]};
            if (k == 0) begin
                e_oe[i] = m_dir[i]; e_out[i] = m_lvl[i];
            end else begin
                e_oe[i] = per_oe[(k-1)*N+i]; e_out[i] = per_out[(k-1)*N+i];
            end
            e_pen[i] = !m_poff[i] && !e_oe[i];
            e_pup[i] = m_lvl[i];
            e_alt[2*i +: 2] = 2'(k);
        end
    endfunction

    task automatic check_pads(input string req);
        model_pads();
        chk({req, " R6 pad_oe"},  64'(pad_oe),  64'(e_oe));
        chk({req, " R6 pad_out"}, 64'(pad_out), 64'(e_out));
        chk({req, " R4 pull_en"}, 64'(pad_pull_en), 64'(e_pen));
        chk({req, " R4 pull_up"}, 64'(pad_pull_up), 64'(e_pup));
        chk({req, " R6 pad_alt"}, pad_alt, e_alt);
    endtask

    // Called at a negedge; returns at a negedge with the bus idle.
    task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] w);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = w;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        model_write(a, w);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [N-1:0] r);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        #1 chk("R9 setup-phase prdata", 64'(prdata), 64'd0);
        @(negedge clk); penable = 1'b1;
        #1 r = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a, input logic [N-1:0] pins);
        logic [N-1:0] r;
        bus_read(a, r);
        chk(req, 64'(r), 64'(model_read(a, pins)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    localparam logic [AW-1:0] ADDRS [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                            8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'hFC};

    initial begin : stim
        logic [N-1:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_pads("R1 in reset");
        chk("R1 pull_en all", 64'(pad_pull_en), 64'(32'hFFFF_FFFF));
        rst_n = 1'b1;
        @(negedge clk);
        check_pads("R1 after release");

        // R2 direct loads and readback
        bus_write(8'h0C, 32'h0F0F_0000); read_check("R2 pulloff", 8'h0C, pad_in);
        bus_write(8'h10, 32'h0000_FFFF); read_check("R2 dir", 8'h10, pad_in);
        bus_write(8'h00, 32'hA5A5_A5A5); check_pads("R2 level");
        // R3 set/clear aliases
        bus_write(8'h04, 32'h0000_000F); check_pads("R3 level set");
        bus_write(8'h08, 32'h8000_0001); check_pads("R3 level clear");
        bus_write(8'h14, 32'h00F0_0000); read_check("R3 dir set", 8'h10, pad_in);
        bus_write(8'h18, 32'h0000_0F00); read_check("R3 dir clear", 8'h10, pad_in);
        bus_write(8'h04, 32'h0); check_pads("R3 zero set no change");
        // R4 pull follows level for inputs only
        bus_write(8'h0C, 32'h0); check_pads("R4 pull on");
        // R6 alternate codes
        per_out = {$urandom, $urandom, $urandom};
        per_oe  = {$urandom, $urandom, $urandom};
        bus_write(8'h20, 32'hF0F0_F0F0);
        bus_write(8'h24, 32'hFF00_FF00); check_pads("R6 alt codes");
        read_check("R2 alt A", 8'h20, pad_in);
        read_check("R2 alt B", 8'h24, pad_in);
        // R7 reserved and unmapped writes
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_write(8'hFC, 32'hFFFF_FFFF);
        check_pads("R7 ignored writes");
        read_check("R7 pulloff unchanged", 8'h0C, pad_in);
        read_check("R7 dir unchanged", 8'h10, pad_in);
        read_check("R7 alias read 04", 8'h04, pad_in);
        read_check("R7 alias read 18", 8'h18, pad_in);
        read_check("R7 reserved read 1C", 8'h1C, pad_in);
        read_check("R7 unmapped read 28", 8'h28, pad_in);
        // R8 enable without setup phase
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 8'h00; pwdata = ~m_lvl;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        check_pads("R8 no-setup write ignored");
        // R5 synchronizer latency
        pad_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        read_check("R5 settled", 8'h00, pad_in);
        pad_in = 32'hCAFE_F00D;
        bus_read(8'h00, r);
        chk("R5 one edge not visible", 64'(r), 64'(32'h1234_5678));
        bus_read(8'h00, r);
        chk("R5 two edges visible", 64'(r), 64'(32'hCAFE_F00D));
        // R9 idle bus
        @(negedge clk); #1 chk("R9 idle prdata", 64'(prdata), 64'd0);

        // Constrained random traffic
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5) begin
                bus_write(ADDRS[$urandom_range(0, 11)], $urandom);
                check_pads("R3 random write");
            end else if (op < 8) begin
                read_check("R2 random read", ADDRS[$urandom_range(0, 11)], pad_in);
            end else if (op == 8) begin
                pad_in = $urandom;
                repeat (3) @(negedge clk);
                read_check("R5 random pins", 8'h00, pad_in);
            end else begin
                per_out = {$urandom, $urandom, $urandom};
                per_oe  = {$urandom, $urandom, $urandom};
                #1 check_pads("R6 random peripheral");
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule